// File: doc/BRIEF.md
# Host-to-Network-Controller Bridge with Windowed Packet RAM

This block sits between a 24-bit host bus and a small network controller. Each host access carries an address, write data, a size of one, two or four bytes, and a read or a write strobe. The bridge decodes the address into one of five targets: a local packet RAM, a 512-byte bank of bridge registers, a configuration-space window, a window onto the controller's I/O ports, or nothing at all. The two windows are not terminated inside the bridge. They are forwarded as strobes with the low address byte, the size and the write data, and the read data comes back on side inputs.

The packet RAM is shared with the controller, which reaches it through a direct port that wins every conflict. A second host alias of the RAM adds a programmable offset to the address, so the host can follow the controller's ring position without computing addresses itself. Multi-byte accesses that run past the top of the RAM continue at address zero. The bridge also combines the controller's interrupt request with an enable byte to drive the host interrupt, and it turns a register write into a one-cycle reset pulse for the controller.

Top module: `pci_win_bridge`

## Requirements
- R1: A host access with address bits 23:16 equal to 0x84 targets the packet RAM at byte address `addr mod 2^RAM_AW` (0xFFF with the default RAM_AW of 12). Data is little-endian. A write changes only the bytes its size covers. Size code 0 is one byte, code 1 is two bytes, and codes 2 and 3 are four bytes. A read returns zero in the bytes above its size.
- R2: When bit 15 of a RAM access address is set, the stored DMA offset is added to the address before the mask is applied.
- R3: When a multi-byte RAM access runs past the top of the RAM, the remaining bytes are read from or written to address 0 onwards, in order.
- R4: Host addresses 0x001400 to 0x0015FF select the register bank, with byte offset equal to address bits 8:0. The register bank can be read and written with any size.
- R5: After reset, register bytes 0x00 to 0x0F hold the ASCII string "PKTBRIDGE_WIN_V1" with the first character at offset 0x00. Bytes 0x1C to 0x1F hold "NETB". Every other register byte is zero.
- R6: Addresses 0x001600 to 0x0016FF raise `cfg_rd_o` or `cfg_wr_o`, and addresses 0x001700 to 0x0017FF raise `io_rd_o` or `io_wr_o`. Each strobe is combinational, comes with address bits 7:0, the size and the write data, and at most one strobe is high at a time. For a read, the side read data is returned to the host.
- R7: `irq_o` is high exactly when `ctl_irq_i` is high and register byte 0x14 is nonzero. It follows a change of the input in the same cycle, and a register write in the next cycle.
- R8: A write that starts at register offset 0x18 with data bit 0 set gives `ctl_rst_o` high for exactly the next cycle. A read that starts at 0x18 returns only that byte, with bits 31:8 zero.
- R9: A write that starts at register offset 0x2C loads the DMA offset with the bytes covered by its size, masked to the RAM address width.
- R10: A read from an address that selects no target returns 0xFFFFFFFF. A write to such an address changes no state and raises no strobe.
- R11: The controller port reads and writes the RAM at `dma_addr_i`, with read data valid (`dma_rvalid_o`) in the cycle after the request. When the controller port is requesting, a host RAM access sees `hst_ready_o` low and is not performed that cycle.
- R12: A host read accepted in one cycle (strobe high with `hst_ready_o` high) returns its data with `hst_rvalid_o` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_addr_i | input | 24 | Host byte address |
| hst_wdata_i | input | 32 | Host write data, little-endian |
| hst_size_i | input | 2 | Access size code: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes |
| hst_rd_i | input | 1 | Host read strobe; wins if both strobes are high |
| hst_wr_i | input | 1 | Host write strobe |
| hst_ready_o | output | 1 | Host access accepted this cycle |
| hst_rvalid_o | output | 1 | Host read data valid |
| hst_rdata_o | output | 32 | Host read data |
| dma_req_i | input | 1 | Controller RAM request |
| dma_we_i | input | 1 | Controller request is a write |
| dma_addr_i | input | RAM_AW | Controller RAM byte address |
| dma_size_i | input | 2 | Controller access size code |
| dma_wdata_i | input | 32 | Controller write data |
| dma_rvalid_o | output | 1 | Controller read data valid |
| dma_rdata_o | output | 32 | Controller read data |
| win_addr_o | output | 8 | Window offset, address bits 7:0 |
| win_size_o | output | 2 | Window access size code |
| win_wdata_o | output | 32 | Window write data |
| cfg_rd_o | output | 1 | Configuration window read strobe |
| cfg_wr_o | output | 1 | Configuration window write strobe |
| cfg_rdata_i | input | 32 | Configuration window read data |
| io_rd_o | output | 1 | Controller I/O window read strobe |
| io_wr_o | output | 1 | Controller I/O window write strobe |
| io_rdata_i | input | 32 | Controller I/O window read data |
| ctl_irq_i | input | 1 | Controller interrupt request |
| irq_o | output | 1 | Interrupt to the host |
| ctl_rst_o | output | 1 | One-cycle reset pulse to the controller |

## Verification
A wrong DMA offset does not show at once. It appears only on the next host access through the alias region, as data from the wrong RAM location, so the tests program the offset and then read back through the alias. A wrong lane rotation or wrap computation shows in the cycle after a read, as bytes that are swapped or lost, which is why unaligned accesses and accesses that cross the top of the RAM are read back byte-exactly. A corrupted interrupt-enable byte or reset decode shows within one cycle on `irq_o` or `ctl_rst_o`. Arbitration faults show as a host stall that never happens, or as a host access that goes ahead in the same cycle as a controller request.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_REGS,
    RG_CFG,
    RG_IO
  } region_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
  import pwb_pkg::*;
#(
  parameter logic [7:0] RAM_PAGE = 8'h84
) (
  input  logic [23:0] addr_i,
  output region_e     region_o
);

  always_comb begin
    region_o = RG_NONE;
    if (addr_i[23:16] == RAM_PAGE) begin
      region_o = RG_RAM;
    end else if (addr_i[23:16] == 8'h00) begin
      case (addr_i[15:8])
        8'h14, 8'h15: region_o = RG_REGS;
        8'h16:        region_o = RG_CFG;
        8'h17:        region_o = RG_IO;
        default:      region_o = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pwb_ram.sv
// Byte-laned RAM with one shared port; wrap falls out of the address width.
module pwb_ram
  import pwb_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);

  localparam int WAW   = AW - 2;
  localparam int WORDS = 1 << WAW;

  logic [2:0]  nbytes;
  logic [31:0] rd_lanes;
  logic [1:0]  lane0_q;
  logic [1:0]  size_q;

  assign nbytes = size_bytes(size_i);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [1:0]    off;
    logic [AW-1:0] baddr;
    logic [WAW-1:0] word;
    logic          en;
    logic [7:0]    wbyte;
    logic [7:0]    mem_q [WORDS];
    logic [7:0]    rd_q;

    assign off   = 2'(l) - addr_i[1:0];
    assign baddr = addr_i + AW'(off);
    assign word  = baddr[AW-1:2];
    assign en    = {1'b0, off} < nbytes;
    assign wbyte = wdata_i[{off, 3'b000} +: 8];

    always_ff @(posedge clk_i) begin
      if (req_i && we_i && en) mem_q[word] <= wbyte;
      if (req_i && !we_i)      rd_q <= mem_q[word];
    end

    assign rd_lanes[8*l +: 8] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane0_q <= '0;
      size_q  <= '0;
    end else if (req_i && !we_i) begin
      lane0_q <= addr_i[1:0];
      size_q  <= size_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] ln;
      ln = lane0_q + 2'(i);
      if (3'(i) < size_bytes(size_q)) rdata_o[8*i +: 8] = rd_lanes[8*ln +: 8];
    end
  end

endmodule

// File: rtl/pwb_regs.sv
module pwb_regs
  import pwb_pkg::*;
#(
  parameter int           AW      = 12,
  parameter logic [127:0] ID_STR  = "PKTBRIDGE_WIN_V1",
  parameter logic [31:0]  TAG_STR = "NETB"
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic [8:0]    off_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_en_o,
  output logic          rst_pulse_o,
  output logic [AW-1:0] dma_off_o
);

  localparam int          BANK    = 512;
  localparam logic [8:0]  OFF_IEN = 9'h014;
  localparam logic [8:0]  OFF_RST = 9'h018;
  localparam logic [8:0]  OFF_TAG = 9'h01C;
  localparam logic [8:0]  OFF_DOF = 9'h02C;

  logic [7:0]    bank_q [BANK];
  logic          pulse_q;
  logic [AW-1:0] dof_q;
  logic [2:0]    nbytes;
  logic [31:0]   wmasked;

  assign nbytes  = size_bytes(size_i);
  assign wmasked = wdata_i & size_mask(size_i);

  function automatic logic [7:0] init_byte(input int k);
    if (k < 16) return ID_STR[8*(15-k) +: 8];
    if (k >= int'(OFF_TAG) && k < int'(OFF_TAG) + 4) return TAG_STR[8*(int'(OFF_TAG)+3-k) +: 8];
    return 8'h00;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < BANK; k++) bank_q[k] <= init_byte(k);
    end else if (acc_i && we_i) begin
      for (int i = 0; i < 4; i++) begin
        if (3'(i) < nbytes) bank_q[off_i + 9'(i)] <= wdata_i[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      dof_q   <= '0;
    end else begin
      pulse_q <= acc_i && we_i && (off_i == OFF_RST) && wdata_i[0];
      if (acc_i && we_i && off_i == OFF_DOF) dof_q <= wmasked[AW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < nbytes) rdata_o[8*i +: 8] = bank_q[off_i + 9'(i)];
    end
    if (off_i == OFF_RST) rdata_o[31:8] = '0;
  end

  assign irq_en_o    = |bank_q[OFF_IEN];
  assign rst_pulse_o = pulse_q;
  assign dma_off_o   = dof_q;

endmodule

// File: rtl/pci_win_bridge.sv
module pci_win_bridge
  import pwb_pkg::*;
#(
  parameter int           RAM_AW   = 12,
  parameter logic [7:0]   RAM_PAGE = 8'h84,
  parameter logic [127:0] ID_STR   = "PKTBRIDGE_WIN_V1",
  parameter logic [31:0]  TAG_STR  = "NETB"
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [23:0]       hst_addr_i,
  input  logic [31:0]       hst_wdata_i,
  input  logic [1:0]        hst_size_i,
  input  logic              hst_rd_i,
  input  logic              hst_wr_i,
  output logic              hst_ready_o,
  output logic              hst_rvalid_o,
  output logic [31:0]       hst_rdata_o,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [RAM_AW-1:0] dma_addr_i,
  input  logic [1:0]        dma_size_i,
  input  logic [31:0]       dma_wdata_i,
  output logic              dma_rvalid_o,
  output logic [31:0]       dma_rdata_o,
  output logic [7:0]        win_addr_o,
  output logic [1:0]        win_size_o,
  output logic [31:0]       win_wdata_o,
  output logic              cfg_rd_o,
  output logic              cfg_wr_o,
  input  logic [31:0]       cfg_rdata_i,
  output logic              io_rd_o,
  output logic              io_wr_o,
  input  logic [31:0]       io_rdata_i,
  input  logic              ctl_irq_i,
  output logic              irq_o,
  output logic              ctl_rst_o
);

  localparam int ALIAS_BIT = 15;

  region_e           region;
  logic              hst_acc, hst_we, host_ram, host_go;
  logic [RAM_AW-1:0] dma_off, host_phys;
  logic              ram_req, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [1:0]        ram_size;
  logic [31:0]       ram_wdata, ram_rdata;
  logic [31:0]       reg_rdata, hold_d;
  logic              irq_en;
  logic              hst_rv_q, dma_rv_q, src_ram_q;
  logic [31:0]       hold_q;

  pwb_decode #(.RAM_PAGE(RAM_PAGE)) u_dec (
    .addr_i  (hst_addr_i),
    .region_o(region)
  );

  assign hst_acc     = hst_rd_i | hst_wr_i;
  assign hst_we      = hst_wr_i & ~hst_rd_i;
  assign host_ram    = hst_acc && (region == RG_RAM);
  assign hst_ready_o = ~(host_ram & dma_req_i);
  assign host_go     = hst_acc & hst_ready_o;

  // alias region: offset added before the RAM-size truncation
  assign host_phys = hst_addr_i[ALIAS_BIT] ? hst_addr_i[RAM_AW-1:0] + dma_off
                                           : hst_addr_i[RAM_AW-1:0];

  always_comb begin
    if (dma_req_i) begin
      ram_req   = 1'b1;
      ram_we    = dma_we_i;
      ram_addr  = dma_addr_i;
      ram_size  = dma_size_i;
      ram_wdata = dma_wdata_i;
    end else begin
      ram_req   = host_go && (region == RG_RAM);
      ram_we    = hst_we;
      ram_addr  = host_phys;
      ram_size  = hst_size_i;
      ram_wdata = hst_wdata_i;
    end
  end

  pwb_ram #(.AW(RAM_AW)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ram_req),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .size_i (ram_size),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  pwb_regs #(.AW(RAM_AW), .ID_STR(ID_STR), .TAG_STR(TAG_STR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (host_go && (region == RG_REGS)),
    .we_i       (hst_we),
    .off_i      (hst_addr_i[8:0]),
    .size_i     (hst_size_i),
    .wdata_i    (hst_wdata_i),
    .rdata_o    (reg_rdata),
    .irq_en_o   (irq_en),
    .rst_pulse_o(ctl_rst_o),
    .dma_off_o  (dma_off)
  );

  assign win_addr_o  = hst_addr_i[7:0];
  assign win_size_o  = hst_size_i;
  assign win_wdata_o = hst_wdata_i;
  assign cfg_rd_o    = hst_rd_i && (region == RG_CFG);
  assign cfg_wr_o    = hst_we   && (region == RG_CFG);
  assign io_rd_o     = hst_rd_i && (region == RG_IO);
  assign io_wr_o     = hst_we   && (region == RG_IO);

  always_comb begin
    case (region)
      RG_REGS: hold_d = reg_rdata;
      RG_CFG:  hold_d = cfg_rdata_i;
      RG_IO:   hold_d = io_rdata_i;
      default: hold_d = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hst_rv_q  <= 1'b0;
      dma_rv_q  <= 1'b0;
      src_ram_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      hst_rv_q <= host_go && hst_rd_i;
      dma_rv_q <= dma_req_i && !dma_we_i;
      if (host_go && hst_rd_i) begin
        src_ram_q <= (region == RG_RAM);
        hold_q    <= hold_d;
      end
    end
  end

  assign hst_rvalid_o = hst_rv_q;
  assign hst_rdata_o  = src_ram_q ? ram_rdata : hold_q;
  assign dma_rvalid_o = dma_rv_q;
  assign dma_rdata_o  = ram_rdata;
  assign irq_o        = ctl_irq_i & irq_en;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [23:0] hst_addr_i,
  input logic        wr_bit0_i,
  input logic        hst_rd_i,
  input logic        hst_wr_i,
  input logic        hst_ready_o,
  input logic        hst_rvalid_o,
  input logic        dma_req_i,
  input logic        dma_we_i,
  input logic        dma_rvalid_o,
  input logic        cfg_rd_o,
  input logic        cfg_wr_o,
  input logic        io_rd_o,
  input logic        io_wr_o,
  input logic        ctl_irq_i,
  input logic        irq_o,
  input logic        ctl_rst_o
);

  logic ram_hit;
  assign ram_hit = hst_addr_i[23:16] == 8'h84;

  p_win_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_rd_o, cfg_wr_o, io_rd_o, io_wr_o}));

  p_cfg_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_o || cfg_wr_o) |-> (hst_addr_i[23:8] == 16'h0016));

  p_irq_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_irq_i);

  p_rst_from_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_o |-> $past(hst_wr_i && wr_bit0_i));

  p_host_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_i && ram_hit && (hst_rd_i || hst_wr_i)) |-> !hst_ready_o);

  p_dma_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rvalid_o |-> $past(dma_req_i && !dma_we_i));

  p_host_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_rvalid_o |-> $past(hst_rd_i && hst_ready_o));

endmodule

bind pci_win_bridge pwb_checker u_pwb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_addr_i  (hst_addr_i),
  .wr_bit0_i   (hst_wdata_i[0]),
  .hst_rd_i    (hst_rd_i),
  .hst_wr_i    (hst_wr_i),
  .hst_ready_o (hst_ready_o),
  .hst_rvalid_o(hst_rvalid_o),
  .dma_req_i   (dma_req_i),
  .dma_we_i    (dma_we_i),
  .dma_rvalid_o(dma_rvalid_o),
  .cfg_rd_o    (cfg_rd_o),
  .cfg_wr_o    (cfg_wr_o),
  .io_rd_o     (io_rd_o),
  .io_wr_o     (io_wr_o),
  .ctl_irq_i   (ctl_irq_i),
  .irq_o       (irq_o),
  .ctl_rst_o   (ctl_rst_o)
);

// File: tb/test_pci_win_bridge.sv
`timescale 1ns/1ps
module test_pci_win_bridge;

  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [23:0]   hst_addr_i = '0;
  logic [31:0]   hst_wdata_i = '0;
  logic [1:0]    hst_size_i = '0;
  logic          hst_rd_i = 1'b0, hst_wr_i = 1'b0;
  logic          hst_ready_o, hst_rvalid_o;
  logic [31:0]   hst_rdata_o;
  logic          dma_req_i = 1'b0, dma_we_i = 1'b0;
  logic [AW-1:0] dma_addr_i = '0;
  logic [1:0]    dma_size_i = '0;
  logic [31:0]   dma_wdata_i = '0;
  logic          dma_rvalid_o;
  logic [31:0]   dma_rdata_o;
  logic [7:0]    win_addr_o;
  logic [1:0]    win_size_o;
  logic [31:0]   win_wdata_o;
  logic          cfg_rd_o, cfg_wr_o, io_rd_o, io_wr_o;
  logic [31:0]   cfg_rdata_i = 32'hCAFE_F00D;
  logic [31:0]   io_rdata_i  = 32'h0BAD_BEEF;
  logic          ctl_irq_i = 1'b0;
  logic          irq_o, ctl_rst_o;

  int n_run = 0, n_fail = 0, n_stall = 0;

  always #2.5 clk_i = ~clk_i;

  pci_win_bridge #(.RAM_AW(AW)) i_pci_win_bridge (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one host access; returns read data sampled the cycle after acceptance
  task automatic hacc(input logic rd, input logic [23:0] a, input logic [31:0] d,
                      input logic [1:0] sz, output logic [31:0] q);
    logic rdy;
    @(negedge clk_i);
    hst_addr_i = a; hst_wdata_i = d; hst_size_i = sz;
    hst_rd_i = rd; hst_wr_i = !rd;
    forever begin
      #1 rdy = hst_ready_o;
      if (!rdy) n_stall++;
      @(posedge clk_i);
      if (rdy) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    q = hst_rdata_o;
    if (rd) chk("R12 rvalid", 32'(hst_rvalid_o), 32'd1);
    hst_rd_i = 1'b0; hst_wr_i = 1'b0;
  endtask

  task automatic hwr(input logic [23:0] a, input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] unused_q;
    hacc(1'b0, a, d, sz, unused_q);
  endtask

  task automatic hrd_chk(input string req, input logic [23:0] a, input logic [1:0] sz,
                         input logic [31:0] exp);
    logic [31:0] q;
    hacc(1'b1, a, 32'h0, sz, q);
    chk(req, q, exp);
  endtask

  task automatic dma_op(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [1:0] sz, output logic [31:0] q);
    @(negedge clk_i);
    dma_req_i = 1'b1; dma_we_i = we; dma_addr_i = a; dma_wdata_i = d; dma_size_i = sz;
    @(posedge clk_i);
    @(negedge clk_i);
    q = dma_rdata_o;
    if (!we) chk("R11 dma rvalid", 32'(dma_rvalid_o), 32'd1);
    dma_req_i = 1'b0; dma_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R7 irq after reset", 32'(irq_o), 32'd0);
    chk("R8 no pulse after reset", 32'(ctl_rst_o), 32'd0);
    chk("R11 ready idle", 32'(hst_ready_o), 32'd1);
    hrd_chk("R5 id word 0", 24'h001400, 2'd2, 32'h4254_4B50);
    hrd_chk("R5 id word 3", 24'h00140C, 2'd2, 32'h3156_5F4E);
    hrd_chk("R5 tag", 24'h00141C, 2'd2, 32'h4254_454E);
    hrd_chk("R5 zero byte", 24'h001420, 2'd2, 32'h0);
    hrd_chk("R4 upper half", 24'h0015F0, 2'd2, 32'h0);
  endtask

  task automatic t_ram_basic;
    hwr(24'h840010, 32'hDEAD_BEEF, 2'd2);
    hrd_chk("R1 word rw", 24'h840010, 2'd2, 32'hDEAD_BEEF);
    hwr(24'h840011, 32'hFFFF_FF55, 2'd0);
    hrd_chk("R1 byte write lanes", 24'h840010, 2'd2, 32'hDEAD_55EF);
    hrd_chk("R1 half read", 24'h840012, 2'd1, 32'h0000_DEAD);
    hwr(24'h840040, 32'h0, 2'd2);
    hwr(24'h840044, 32'h0, 2'd2);
    hwr(24'h840041, 32'h1234_5678, 2'd2);
    hrd_chk("R1 unaligned low", 24'h840040, 2'd2, 32'h3456_7800);
    hrd_chk("R1 unaligned high", 24'h840044, 2'd0, 32'h0000_0012);
    hrd_chk("R1 high bits masked", 24'h841010, 2'd2, 32'hDEAD_55EF);
  endtask

  task automatic t_wrap;
    hwr(24'h840FFE, 32'h1122_3344, 2'd2);
    hrd_chk("R3 wrapped bytes at 0", 24'h840000, 2'd1, 32'h0000_1122);
    hrd_chk("R3 wrapped read", 24'h840FFE, 2'd2, 32'h1122_3344);
    hrd_chk("R3 top byte", 24'h840FFF, 2'd0, 32'h0000_0033);
  endtask

  task automatic t_alias;
    hrd_chk("R2 zero offset alias", 24'h848010, 2'd2, 32'hDEAD_55EF);
    hwr(24'h00142C, 32'hFFFF_F123, 2'd2);
    hwr(24'h848000, 32'hCAFE_BABE, 2'd2);
    hrd_chk("R2 alias write lands at offset", 24'h840123, 2'd2, 32'hCAFE_BABE);
    hrd_chk("R9 alias byte read", 24'h848001, 2'd0, 32'h0000_00BA);
    hrd_chk("R4 raw offset reg", 24'h00142C, 2'd2, 32'hFFFF_F123);
    hwr(24'h840014, 32'h0A0B_0C0D, 2'd2);
    hwr(24'h00142C, 32'hFFFF_FF05, 2'd0);
    hrd_chk("R9 byte-size offset load", 24'h84800F, 2'd2, 32'h0A0B_0C0D);
  endtask

  task automatic t_ctl_reset;
    hwr(24'h001418, 32'h0000_0301, 2'd2);
    chk("R8 pulse high", 32'(ctl_rst_o), 32'd1);
    @(negedge clk_i);
    chk("R8 pulse one cycle", 32'(ctl_rst_o), 32'd0);
    hrd_chk("R8 read low byte", 24'h001418, 2'd2, 32'h0000_0001);
    hrd_chk("R4 neighbour byte", 24'h001419, 2'd0, 32'h0000_0003);
    hwr(24'h001418, 32'h0000_0002, 2'd2);
    chk("R8 no pulse bit0 clear", 32'(ctl_rst_o), 32'd0);
  endtask

  task automatic t_irq;
    @(negedge clk_i); ctl_irq_i = 1'b1; #1;
    chk("R7 disabled", 32'(irq_o), 32'd0);
    hwr(24'h001415, 32'h0000_00FF, 2'd0);
    chk("R7 other byte no enable", 32'(irq_o), 32'd0);
    hwr(24'h001414, 32'h0000_0001, 2'd0);
    chk("R7 enabled", 32'(irq_o), 32'd1);
    ctl_irq_i = 1'b0; #1;
    chk("R7 request dropped", 32'(irq_o), 32'd0);
    ctl_irq_i = 1'b1; #1;
    chk("R7 request back", 32'(irq_o), 32'd1);
    hwr(24'h001414, 32'h0000_0000, 2'd0);
    chk("R7 enable cleared", 32'(irq_o), 32'd0);
    ctl_irq_i = 1'b0;
  endtask

  task automatic t_windows;
    logic [31:0] q;
    @(negedge clk_i);
    hst_addr_i = 24'h0016A4; hst_size_i = 2'd1; hst_rd_i = 1'b1; #1;
    chk("R6 cfg strobe", {28'h0, cfg_rd_o, cfg_wr_o, io_rd_o, io_wr_o}, 32'h8);
    chk("R6 cfg offset", 32'(win_addr_o), 32'h0A4);
    chk("R6 cfg size", 32'(win_size_o), 32'd1);
    @(posedge clk_i); @(negedge clk_i);
    chk("R6 cfg read data", hst_rdata_o, 32'hCAFE_F00D);
    hst_rd_i = 1'b0;
    @(negedge clk_i);
    hst_addr_i = 24'h001733; hst_wdata_i = 32'h5A5A_0001; hst_size_i = 2'd2; hst_wr_i = 1'b1; #1;
    chk("R6 io write strobe", {28'h0, cfg_rd_o, cfg_wr_o, io_rd_o, io_wr_o}, 32'h1);
    chk("R6 io data", win_wdata_o, 32'h5A5A_0001);
    @(posedge clk_i); @(negedge clk_i);
    hst_wr_i = 1'b0;
    hacc(1'b1, 24'h001780, 32'h0, 2'd2, q);
    chk("R6 io read data", q, 32'h0BAD_BEEF);
  endtask

  task automatic t_miss;
    hrd_chk("R10 unmapped read", 24'h200000, 2'd2, 32'hFFFF_FFFF);
    hrd_chk("R10 gap read", 24'h001800, 2'd0, 32'hFFFF_FFFF);
    @(negedge clk_i);
    hst_addr_i = 24'h001300; hst_wdata_i = 32'h0; hst_size_i = 2'd2; hst_wr_i = 1'b1; #1;
    chk("R10 no strobe", {28'h0, cfg_rd_o, cfg_wr_o, io_rd_o, io_wr_o}, 32'h0);
    @(posedge clk_i); @(negedge clk_i);
    hst_wr_i = 1'b0;
    hwr(24'h011400, 32'h0, 2'd2);
    hrd_chk("R10 regs untouched", 24'h001400, 2'd2, 32'h4254_4B50);
  endtask

  task automatic t_dma;
    logic [31:0] q;
    dma_op(1'b0, 12'h010, 32'h0, 2'd2, q);
    chk("R11 dma read", q, 32'hDEAD_55EF);
    dma_op(1'b0, 12'hFFE, 32'h0, 2'd2, q);
    chk("R11 dma read wraps", q, 32'h1122_3344);
    n_stall = 0;
    fork
      begin
        logic [31:0] dq;
        dma_op(1'b1, 12'h020, 32'hA5A5_A5A5, 2'd2, dq);
      end
      begin
        logic [31:0] hq;
        hacc(1'b1, 24'h840020, 32'h0, 2'd2, hq);
        chk("R11 host sees dma data", hq, 32'hA5A5_A5A5);
      end
    join
    chk("R11 one stall cycle", 32'(n_stall), 32'd1);
    n_stall = 0;
    fork
      begin
        logic [31:0] dq;
        dma_op(1'b0, 12'h010, 32'h0, 2'd2, dq);
      end
      hwr(24'h001420, 32'h0000_0077, 2'd0);
    join
    chk("R11 reg access not stalled", 32'(n_stall), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ram_basic();
    t_wrap();
    t_alias();
    t_ctl_reset();
    t_irq();
    t_windows();
    t_miss();
    t_dma();
    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule